// File: doc/BRIEF.md
# Context Identifier Change Trace Emitter

This block follows writes to a 32-bit context identifier register and produces a short trace packet whenever the part of the identifier that is being watched takes a new value. A 2-bit size selector decides how many low-order bytes are watched and carried in the packet: none, one, two or all four. Bytes outside the selected width are forced to zero in the packet, and a change confined to them produces no packet.

Writes aimed at the non-secure copy of the register while the core is in secure state do not alter the current identifier, so they are dropped here. A validity flag tracks whether the stored identifier is known. A parameter picks the reset behaviour. In one variant reset only marks the value unknown and keeps the last value for comparators. In the other, reset loads a fixed value and announces it with a packet in the first cycle after reset. The current identifier and its validity flag are also driven out for downstream comparators.

Top module: `ctxid_trace_emitter`

## Requirements
- R1: While reset is high and in the first cycle after it, with the default parameters, `pkt_valid` is 0 and `cur_ctx_known` is 0.
- R2: A register write that counts, made while `cur_ctx_known` is 0, with `trace_en` high and `trace_size` nonzero, raises `pkt_valid` in the next cycle. This holds even if the watched bytes equal the stored value.
- R3: The packet byte count is 1, 2 or 4 for `trace_size` 2'b01, 2'b10 or 2'b11. `pkt_data` holds the written identifier, and the bits at and above bit 8·count are zero.
- R4: A counted write that changes only bits outside the watched bytes of a known identifier emits no packet. It still updates `cur_ctx_id`.
- R5: A counted write that changes at least one watched bit emits a packet in the next cycle.
- R6: With `trace_en` low or `trace_size` equal to 2'b00, no packet is emitted, but counted writes still update `cur_ctx_id`.
- R7: A write with `sec_state`=1 and `wr_ns_copy`=1 leaves `cur_ctx_id` unchanged and emits no packet.
- R8: A write with `sec_state`=0 counts whatever the value of `wr_ns_copy`. A write with `sec_state`=1 and `wr_ns_copy`=0 also counts.
- R9: With `RST_KNOWN`=0, reset clears `cur_ctx_known` and keeps the previous `cur_ctx_id`.
- R10: With `RST_KNOWN`=1, reset loads `RST_VAL` and sets `cur_ctx_known`. In the cycle after the first clock edge that samples reset low, a packet carries `RST_VAL`, masked to the selected width, if tracing is enabled with a nonzero size.
- R11: Changing `trace_size` or `trace_en` without a write emits no packet.
- R12: `pkt_valid` stays high for a single cycle for each qualifying write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctx_wr_en | input | 1 | Identifier register write strobe |
| ctx_wr_data | input | 32 | Value being written |
| sec_state | input | 1 | Core is in secure state |
| wr_ns_copy | input | 1 | Write targets the non-secure copy |
| trace_size | input | 2 | Watched width: 00 none, 01 one byte, 10 two bytes, 11 four bytes |
| trace_en | input | 1 | Trace enable |
| pkt_valid | output | 1 | One-cycle packet strobe |
| pkt_nbytes | output | 3 | Packet byte count |
| pkt_data | output | 32 | Identifier with unwatched bytes zeroed |
| cur_ctx_id | output | 32 | Current identifier for comparators |
| cur_ctx_known | output | 1 | Current identifier is known |

## Verification
The bench builds two copies of the block on the same stimulus. `u_dut` keeps the default `RST_KNOWN`=0 and reaches the retain-on-reset path, the forced first packet and the secure-copy filter. `u_dut_rk` sets `RST_KNOWN`=1 with a distinctive `RST_VAL`, which brings the announce-after-reset packet and its timing within reach. Writes are chosen so that the upper-byte-only changes, the mask boundaries at 8 and 16 bits, and the size-only changes each show at the ports.

// File: rtl/ctxid_trace_pkg.sv
package ctxid_trace_pkg;

    localparam int CTX_W    = 32;
    localparam int CNT_W    = 3;
    localparam int SIZE_W   = 2;

    typedef enum logic [SIZE_W-1:0] {
        SZ_NONE = 2'b00,
        SZ_BYTE = 2'b01,
        SZ_HALF = 2'b10,
        SZ_WORD = 2'b11
    } ctx_size_e;

    typedef struct packed {
        logic             valid;
        logic [CNT_W-1:0] nbytes;
        logic [CTX_W-1:0] data;
    } ctx_pkt_t;

    function automatic logic [CNT_W-1:0] size_nbytes(input ctx_size_e sz);
        case (sz)
            SZ_BYTE: size_nbytes = 3'd1;
            SZ_HALF: size_nbytes = 3'd2;
            SZ_WORD: size_nbytes = 3'd4;
            default: size_nbytes = 3'd0;
        endcase
    endfunction

    function automatic logic [CTX_W-1:0] size_mask(input ctx_size_e sz);
        logic [CNT_W-1:0] n;
        n = size_nbytes(sz);
        for (int i = 0; i < CTX_W; i++) begin
            size_mask[i] = ((i / 8) < int'(n));
        end
    endfunction

endpackage

// File: rtl/ctxid_store.sv
module ctxid_store
    import ctxid_trace_pkg::*;
#(
    parameter bit             RST_KNOWN = 1'b0,
    parameter logic [CTX_W-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             upd,
    input  logic [CTX_W-1:0] upd_data,
    output logic [CTX_W-1:0] cur_id,
    output logic             cur_known,
    output logic             boot_pending
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_known <= RST_KNOWN;
            if (RST_KNOWN) begin
                cur_id <= RST_VAL;
            end
        end else if (upd) begin
            cur_id    <= upd_data;
            cur_known <= 1'b1;
        end
    end

    generate
        if (RST_KNOWN) begin : g_boot
            logic pend_q;
            always_ff @(posedge clk) begin
                if (rst) pend_q <= 1'b1;
                else     pend_q <= 1'b0;
            end
            assign boot_pending = pend_q;
        end else begin : g_noboot
            assign boot_pending = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/ctxid_change_detect.sv
module ctxid_change_detect
    import ctxid_trace_pkg::*;
(
    input  logic             wr_en,
    input  logic [CTX_W-1:0] wr_data,
    input  logic             sec,
    input  logic             ns_copy,
    input  ctx_size_e        size,
    input  logic             trace_en,
    input  logic [CTX_W-1:0] cur_id,
    input  logic             cur_known,
    input  logic             boot_pending,
    output logic             upd,
    output ctx_pkt_t         next_pkt
);

    logic [CTX_W-1:0] mask;
    logic             tracing;
    logic             watched_diff;
    logic             wr_emit;

    always_comb begin
        mask         = size_mask(size);
        tracing      = trace_en && (size != SZ_NONE);
        upd          = wr_en && !(sec && ns_copy);
        watched_diff = |((wr_data ^ cur_id) & mask);
        wr_emit      = upd && (!cur_known || watched_diff);

        next_pkt.valid  = tracing && (wr_emit || boot_pending);
        next_pkt.nbytes = size_nbytes(size);
        next_pkt.data   = (upd ? wr_data : cur_id) & mask;
    end

endmodule

// File: rtl/ctxid_pkt_reg.sv
module ctxid_pkt_reg
    import ctxid_trace_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  ctx_pkt_t d,
    output ctx_pkt_t q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q.valid <= d.valid;
            if (d.valid) begin
                q.nbytes <= d.nbytes;
                q.data   <= d.data;
            end
        end
    end

endmodule

// File: rtl/ctxid_trace_emitter.sv
module ctxid_trace_emitter
    import ctxid_trace_pkg::*;
#(
    parameter bit               RST_KNOWN = 1'b0,
    parameter logic [CTX_W-1:0] RST_VAL   = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctx_wr_en,
    input  logic [CTX_W-1:0] ctx_wr_data,
    input  logic             sec_state,
    input  logic             wr_ns_copy,
    input  logic [SIZE_W-1:0] trace_size,
    input  logic             trace_en,
    output logic             pkt_valid,
    output logic [CNT_W-1:0] pkt_nbytes,
    output logic [CTX_W-1:0] pkt_data,
    output logic [CTX_W-1:0] cur_ctx_id,
    output logic             cur_ctx_known
);

    logic             upd;
    logic             boot_pending;
    ctx_pkt_t         pkt_d;
    ctx_pkt_t         pkt_q;

    ctxid_store #(
        .RST_KNOWN (RST_KNOWN),
        .RST_VAL   (RST_VAL)
    ) u_store (
        .clk          (clk),
        .rst          (rst),
        .upd          (upd),
        .upd_data     (ctx_wr_data),
        .cur_id       (cur_ctx_id),
        .cur_known    (cur_ctx_known),
        .boot_pending (boot_pending)
    );

    ctxid_change_detect u_detect (
        .wr_en        (ctx_wr_en),
        .wr_data      (ctx_wr_data),
        .sec          (sec_state),
        .ns_copy      (wr_ns_copy),
        .size         (ctx_size_e'(trace_size)),
        .trace_en     (trace_en),
        .cur_id       (cur_ctx_id),
        .cur_known    (cur_ctx_known),
        .boot_pending (boot_pending),
        .upd          (upd),
        .next_pkt     (pkt_d)
    );

    ctxid_pkt_reg u_pkt (
        .clk (clk),
        .rst (rst),
        .d   (pkt_d),
        .q   (pkt_q)
    );

    assign pkt_valid  = pkt_q.valid;
    assign pkt_nbytes = pkt_q.nbytes;
    assign pkt_data   = pkt_q.data;

endmodule

// File: rtl/ctxid_trace_chk.sv
module ctxid_trace_chk (
    input logic        clk,
    input logic        rst,
    input logic        ctx_wr_en,
    input logic        sec_state,
    input logic        wr_ns_copy,
    input logic [1:0]  trace_size,
    input logic        trace_en,
    input logic        pkt_valid,
    input logic [2:0]  pkt_nbytes,
    input logic [31:0] pkt_data,
    input logic [31:0] cur_ctx_id,
    input logic        cur_ctx_known
);

    logic post_rst;
    always_ff @(posedge clk) post_rst <= rst;

    // R3
    nbytes_legal_chk: assert property (@(posedge clk) disable iff (rst)
        pkt_valid |-> (pkt_nbytes == 3'd1 || pkt_nbytes == 3'd2 || pkt_nbytes == 3'd4));

    // R3
    byte_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && pkt_nbytes == 3'd1) |-> (pkt_data[31:8] == 24'd0));

    // R3
    half_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && pkt_nbytes == 3'd2) |-> (pkt_data[31:16] == 16'd0));

    // R7
    ns_from_sec_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ctx_wr_en && sec_state && wr_ns_copy) |=> ($stable(cur_ctx_id) && !pkt_valid));

    // R6
    quiet_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        (ctx_wr_en && (!trace_en || trace_size == 2'b00)) |=> !pkt_valid);

    // R11
    no_write_no_pkt_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctx_wr_en && !post_rst) |=> !pkt_valid);

    // R2
    first_write_pkt_chk: assert property (@(posedge clk) disable iff (rst)
        (ctx_wr_en && !(sec_state && wr_ns_copy) && trace_en
         && trace_size != 2'b00 && !cur_ctx_known) |=> pkt_valid);

endmodule

bind ctxid_trace_emitter ctxid_trace_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .ctx_wr_en     (ctx_wr_en),
    .sec_state     (sec_state),
    .wr_ns_copy    (wr_ns_copy),
    .trace_size    (trace_size),
    .trace_en      (trace_en),
    .pkt_valid     (pkt_valid),
    .pkt_nbytes    (pkt_nbytes),
    .pkt_data      (pkt_data),
    .cur_ctx_id    (cur_ctx_id),
    .cur_ctx_known (cur_ctx_known)
);

// File: tb/ctxid_trace_emitter_tb.sv
module ctxid_trace_emitter_tb;

    localparam logic [31:0] RK_VAL = 32'hA5C3_1E7F;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctx_wr_en = 1'b0;
    logic [31:0] ctx_wr_data = '0;
    logic        sec_state = 1'b0;
    logic        wr_ns_copy = 1'b0;
    logic [1:0]  trace_size = 2'b11;
    logic        trace_en = 1'b1;

    logic        pkt_valid, pkt_valid_rk;
    logic [2:0]  pkt_nbytes, pkt_nbytes_rk;
    logic [31:0] pkt_data, pkt_data_rk;
    logic [31:0] cur_id, cur_id_rk;
    logic        cur_known, cur_known_rk;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    ctxid_trace_emitter u_dut (
        .clk (clk), .rst (rst), .ctx_wr_en (ctx_wr_en), .ctx_wr_data (ctx_wr_data),
        .sec_state (sec_state), .wr_ns_copy (wr_ns_copy), .trace_size (trace_size),
        .trace_en (trace_en), .pkt_valid (pkt_valid), .pkt_nbytes (pkt_nbytes),
        .pkt_data (pkt_data), .cur_ctx_id (cur_id), .cur_ctx_known (cur_known)
    );

    ctxid_trace_emitter #(.RST_KNOWN (1'b1), .RST_VAL (RK_VAL)) u_dut_rk (
        .clk (clk), .rst (rst), .ctx_wr_en (ctx_wr_en), .ctx_wr_data (ctx_wr_data),
        .sec_state (sec_state), .wr_ns_copy (wr_ns_copy), .trace_size (trace_size),
        .trace_en (trace_en), .pkt_valid (pkt_valid_rk), .pkt_nbytes (pkt_nbytes_rk),
        .pkt_data (pkt_data_rk), .cur_ctx_id (cur_id_rk), .cur_ctx_known (cur_known_rk)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        chk(act == exp, tag, act, exp);
    endtask

    // drive one write at a negedge; return at the following negedge,
    // where the packet registered at the intervening edge is visible
    task automatic do_write(input logic [31:0] d, input logic s, input logic ns);
        @(negedge clk);
        ctx_wr_en   = 1'b1;
        ctx_wr_data = d;
        sec_state   = s;
        wr_ns_copy  = ns;
        @(negedge clk);
        ctx_wr_en   = 1'b0;
        sec_state   = 1'b0;
        wr_ns_copy  = 1'b0;
    endtask

    task automatic t_reset;
        trace_en = 1'b1; trace_size = 2'b11;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk_eq("R1 pkt_valid in reset", {31'd0, pkt_valid}, 32'd0);
        chk_eq("R1 known in reset", {31'd0, cur_known}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk_eq("R1 pkt_valid after reset", {31'd0, pkt_valid}, 32'd0);
        chk_eq("R1 known after reset", {31'd0, cur_known}, 32'd0);
        chk_eq("R10 boot pkt valid", {31'd0, pkt_valid_rk}, 32'd1);
        chk_eq("R10 boot pkt nbytes", {29'd0, pkt_nbytes_rk}, 32'd4);
        chk_eq("R10 boot pkt data", pkt_data_rk, RK_VAL);
        chk_eq("R10 boot id", cur_id_rk, RK_VAL);
        chk_eq("R10 boot known", {31'd0, cur_known_rk}, 32'd1);
        @(negedge clk);
        chk_eq("R12 boot pkt single cycle", {31'd0, pkt_valid_rk}, 32'd0);
    endtask

    task automatic t_first_write;
        trace_size = 2'b01;
        do_write(32'h0000_0000, 1'b0, 1'b0);
        chk_eq("R2 first write pkt", {31'd0, pkt_valid}, 32'd1);
        chk_eq("R3 first write nbytes", {29'd0, pkt_nbytes}, 32'd1);
        chk_eq("R2 known set", {31'd0, cur_known}, 32'd1);
        @(negedge clk);
        chk_eq("R12 single cycle", {31'd0, pkt_valid}, 32'd0);
    endtask

    task automatic t_upper_only;
        trace_size = 2'b01;
        do_write(32'hFFFF_FF00, 1'b0, 1'b0);
        chk_eq("R4 no pkt on upper change", {31'd0, pkt_valid}, 32'd0);
        chk_eq("R4 id updated", cur_id, 32'hFFFF_FF00);
    endtask

    task automatic t_change_half;
        trace_size = 2'b10;
        do_write(32'hFFFF_1200, 1'b0, 1'b0);
        chk_eq("R5 pkt on watched change", {31'd0, pkt_valid}, 32'd1);
        chk_eq("R3 half nbytes", {29'd0, pkt_nbytes}, 32'd2);
        chk_eq("R3 half data masked", pkt_data, 32'h0000_1200);
        @(negedge clk);
        chk_eq("R12 single cycle half", {31'd0, pkt_valid}, 32'd0);
    endtask

    task automatic t_word;
        trace_size = 2'b11;
        do_write(32'h89AB_1200, 1'b0, 1'b0);
        chk_eq("R5 pkt on upper change at word size", {31'd0, pkt_valid}, 32'd1);
        chk_eq("R3 word nbytes", {29'd0, pkt_nbytes}, 32'd4);
        chk_eq("R3 word data", pkt_data, 32'h89AB_1200);
    endtask

    task automatic t_size_only;
        bit seen = 1'b0;
        @(negedge clk); trace_size = 2'b01;
        @(negedge clk); seen |= pkt_valid; trace_size = 2'b00;
        @(negedge clk); seen |= pkt_valid; trace_en = 1'b0;
        @(negedge clk); seen |= pkt_valid; trace_en = 1'b1; trace_size = 2'b11;
        @(negedge clk); seen |= pkt_valid;
        @(negedge clk); seen |= pkt_valid;
        chk_eq("R11 no pkt on size change", {31'd0, seen}, 32'd0);
    endtask

    task automatic t_disabled;
        trace_en = 1'b0; trace_size = 2'b11;
        do_write(32'h0000_0001, 1'b0, 1'b0);
        chk_eq("R6 no pkt when disabled", {31'd0, pkt_valid}, 32'd0);
        chk_eq("R6 id updated when disabled", cur_id, 32'h0000_0001);
        trace_en = 1'b1; trace_size = 2'b00;
        do_write(32'h0000_0002, 1'b0, 1'b0);
        chk_eq("R6 no pkt at size none", {31'd0, pkt_valid}, 32'd0);
        chk_eq("R6 id updated at size none", cur_id, 32'h0000_0002);
    endtask

    task automatic t_secure;
        trace_en = 1'b1; trace_size = 2'b11;
        do_write(32'h0000_DEAD, 1'b1, 1'b1);
        chk_eq("R7 no pkt on ns copy from secure", {31'd0, pkt_valid}, 32'd0);
        chk_eq("R7 id held", cur_id, 32'h0000_0002);
        do_write(32'h0000_0003, 1'b0, 1'b1);
        chk_eq("R8 ns state write counts", {31'd0, pkt_valid}, 32'd1);
        chk_eq("R8 ns state data", pkt_data, 32'h0000_0003);
        do_write(32'h0000_0004, 1'b1, 1'b0);
        chk_eq("R8 secure own copy counts", {31'd0, pkt_valid}, 32'd1);
        chk_eq("R8 secure own copy id", cur_id, 32'h0000_0004);
    endtask

    task automatic t_reset_retain;
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk_eq("R9 id retained", cur_id, 32'h0000_0004);
        chk_eq("R9 known cleared", {31'd0, cur_known}, 32'd0);
        do_write(32'h0000_0004, 1'b0, 1'b0);
        chk_eq("R2 same value after reset emits", {31'd0, pkt_valid}, 32'd1);
        chk_eq("R2 data after reset", pkt_data, 32'h0000_0004);
    endtask

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_first_write();
        t_upper_only();
        t_change_half();
        t_word();
        t_size_only();
        t_disabled();
        t_secure();
        t_reset_retain();
        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule